// File: doc/BRIEF.md
# Threshold-Compare Random Trigger Generator

This block produces trigger records at random, unbiased instants for a downstream trigger FIFO. It watches an externally supplied 32-bit sample timestamp. Each time the lowest bit of that timestamp changes, in either direction, the block advances a 32-bit pseudo-random generator. It then compares the new number with a programmable 32-bit threshold.

When the number is strictly below the threshold, the block emits one 72-bit record on a data-plus-valid stream. The record carries the timestamp that caused the evaluation, followed by constant filler fields. The stream has no backpressure, so valid is held for one cycle per hit.

A small register port gives access to the threshold and to a 16-bit sticky error word. The threshold can be rewritten at any time, so software sets the trigger rate by choosing it: with threshold T, the hit probability per evaluation is T / 2^32.

Top module: `rand_trig_gen`

## Requirements
- R1: An evaluation occurs in each cycle in which `ts_in[0]` differs from its value in the previous cycle, whether it rises or falls. Its result appears on `trg_valid`/`trg_data` after the next rising clock edge. A cycle without such a change produces no evaluation, even if the upper timestamp bits change.
- R2: The random source is a 32-bit xorshift generator with shifts left 13, right 17 and left 5. Reset seeds it with 0x2545F491. It advances exactly once per evaluation, and the number compared is the newly advanced value.
- R3: A record is emitted only when the random number is strictly less than the threshold. A threshold of zero never produces a record.
- R4: Record layout: bits [71:40] hold the evaluating timestamp, bits [39:24] (amplitude) and [23:8] (trigger word) are zero, and bits [7:0] are 0xFF.
- R5: `trg_valid` is high for exactly one cycle per hit, and is low after any cycle without a hit.
- R6: Address 0 holds the threshold and is readable and writable at any time. A write in the same cycle as an evaluation applies only from the following evaluation.
- R7: Address 1 is the read-only error word. It reads as bits [15:0] = error bits and upper bits zero. A write to address 1 sets error bit 1.
- R8: A read or write to any address of 2 or above sets error bit 0. Such a read returns zero.
- R9: Error bits are sticky until reset. Reset clears the threshold and the error bits, and reseeds the generator.
- R10: The first cycle after reset release only records the reference LSB value, so no evaluation happens in it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_in | input | 32 | Current sample timestamp |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| trg_valid | output | 1 | Record valid, one cycle per hit |
| trg_data | output | 72 | Trigger record |

## Verification
Two functions can fall in the same cycle: a threshold write and an evaluation. The bench provokes this by toggling the timestamp LSB in the very cycle that it writes a new threshold. It does so once with a threshold going from zero to all ones, and once going from all ones back to zero. In each case the evaluation must follow the old threshold, and only the next toggle may see the new one. Back-to-back toggles on consecutive cycles are also driven, and each hit is judged against a bench model of the generator sequence.

// File: rtl/rtrig_pkg.sv
package rtrig_pkg;
  localparam int TS_W   = 32;
  localparam int AMP_W  = 16;
  localparam int WORD_W = 16;
  localparam int LOG_W  = 8;
  localparam int REC_W  = TS_W + AMP_W + WORD_W + LOG_W;
  localparam logic [31:0] RNG_SEED = 32'h2545F491;

  // One xorshift step (13, 17, 5)
  function automatic logic [31:0] rng_step(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // Fake trigger-primitive record: timestamp, zero fields, all-ones logic bits
  function automatic logic [REC_W-1:0] make_record(input logic [TS_W-1:0] ts);
    return {ts, {AMP_W{1'b0}}, {WORD_W{1'b0}}, {LOG_W{1'b1}}};
  endfunction
endpackage

// File: rtl/rtrig_edge.sv
module rtrig_edge (
  input  logic clk,
  input  logic rst,
  input  logic lsb_in,
  output logic evt
);
  logic lsb_q;
  logic primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lsb_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      lsb_q    <= lsb_in;
      primed_q <= 1'b1;
    end
  end

  assign evt = primed_q && (lsb_in != lsb_q);

  // R10
  no_evt_unprimed_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !evt);
endmodule

// File: rtl/rtrig_rng.sv
module rtrig_rng
  import rtrig_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        adv,
  output logic [31:0] next_val
);
  logic [31:0] state_q;

  assign next_val = rng_step(state_q);

  always_ff @(posedge clk) begin
    if (rst)      state_q <= RNG_SEED;
    else if (adv) state_q <= next_val;
  end

  // R2
  rng_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(state_q));
  // R2
  rng_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != 32'h0);
endmodule

// File: rtl/rtrig_regs.sv
module rtrig_regs #(
  parameter int AW  = 4,
  parameter int DW  = 32,
  parameter int EW  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] thr
);
  localparam logic [AW-1:0] A_THR = AW'(0);
  localparam logic [AW-1:0] A_ERR = AW'(1);
  localparam int E_ADDR = 0;
  localparam int E_VAL  = 1;

  logic [EW-1:0] err_q;
  logic [DW-1:0] thr_q;
  logic          bad_addr;
  logic          ro_write;

  assign bad_addr = (wr || rd) && (addr != A_THR) && (addr != A_ERR);
  assign ro_write = wr && (addr == A_ERR);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= '0;
      err_q <= '0;
    end else begin
      if (wr && addr == A_THR) thr_q <= wdata;
      if (bad_addr) err_q[E_ADDR] <= 1'b1;
      if (ro_write) err_q[E_VAL]  <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_THR)      rdata = thr_q;
    else if (addr == A_ERR) rdata = DW'(err_q);
  end

  assign thr = thr_q;

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((err_q & $past(err_q)) == $past(err_q)));
  // R7
  ro_write_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_ERR) |=> err_q[E_VAL]);
  // R8
  bad_addr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ((wr || rd) && addr > A_ERR) |=> err_q[E_ADDR]);
endmodule

// File: rtl/rand_trig_gen.sv
module rand_trig_gen
  import rtrig_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] ts_in,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        trg_valid,
  output logic [71:0] trg_data
);
  logic        evt;
  logic [31:0] rnd;
  logic [31:0] thr;
  logic        hit;

  rtrig_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .lsb_in (ts_in[0]),
    .evt    (evt)
  );

  rtrig_rng u_rng (
    .clk      (clk),
    .rst      (rst),
    .adv      (evt),
    .next_val (rnd)
  );

  rtrig_regs #(.AW(4), .DW(32), .EW(16)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .rd    (reg_rd),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .thr   (thr)
  );

  assign hit = evt && (rnd < thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      trg_valid <= 1'b0;
      trg_data  <= '0;
    end else begin
      trg_valid <= hit;
      if (hit) trg_data <= make_record(ts_in);
    end
  end

  // R5
  valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    trg_valid |-> $past(evt));
  // R3
  zero_thr_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && thr == 32'h0) |=> !trg_valid);
  // R4
  rec_format_chk: assert property (@(posedge clk) disable iff (rst)
    trg_valid |-> (trg_data[7:0] == 8'hFF && trg_data[39:8] == 32'h0));
  // R1
  rec_stamp_chk: assert property (@(posedge clk) disable iff (rst)
    trg_valid |-> trg_data[71:40] == $past(ts_in));
endmodule

// File: tb/rand_trig_gen_tb.sv
module rand_trig_gen_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] ts_in;
  logic        reg_wr, reg_rd;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        trg_valid;
  logic [71:0] trg_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] m_rng;
  logic [31:0] m_thr;

  always #2 clk = ~clk;

  rand_trig_gen u_dut (
    .clk(clk), .rst(rst), .ts_in(ts_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .trg_valid(trg_valid), .trg_data(trg_data)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=50000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] model_step(input logic [31:0] v);
    logic [31:0] a, b, c;
    a = {v[18:0], 13'b0} ^ v;
    b = {17'b0, a[31:17]} ^ a;
    c = {b[26:0], 5'b0} ^ b;
    return c;
  endfunction

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    m_rng = 32'h2545F491; m_thr = 0;
    @(negedge clk);
  endtask

  // drive new timestamp; if LSB changed, judge the evaluation
  task automatic drive_ts(input logic [31:0] nts, input string req);
    logic tog;
    logic exp_hit;
    tog = (nts[0] != ts_in[0]);
    ts_in = nts;
    @(posedge clk); #1;
    exp_hit = 1'b0;
    if (tog) begin
      m_rng = model_step(m_rng);
      exp_hit = (m_rng < m_thr);
    end
    chk(req, 72'(trg_valid), 72'(exp_hit));
    if (exp_hit)
      chk({req, " R4"}, trg_data, {nts, 32'h0, 8'hFF});
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (a == 0) m_thr = d;
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string req);
    reg_rd = 1; reg_addr = a;
    #1;
    chk(req, 72'(reg_rdata), 72'(exp));
    @(negedge clk);
    reg_rd = 0; reg_addr = 0;
  endtask

  task automatic t_reset_state();
    chk("R9 valid after reset", 72'(trg_valid), 72'd0);
    rd_check(0, 32'h0, "R9 thr cleared");
    rd_check(1, 32'h0, "R9 err cleared");
  endtask

  task automatic t_zero_thr();
    int hits = 0;
    for (int i = 0; i < 40; i++) begin
      ts_in = ts_in + 1;
      @(posedge clk); #1;
      m_rng = model_step(m_rng);
      if (trg_valid) hits++;
      @(negedge clk);
    end
    chk("R3 zero threshold never fires", 72'(hits), 72'd0);
  endtask

  task automatic t_full_thr();
    wr_reg(0, 32'hFFFF_FFFF);
    rd_check(0, 32'hFFFF_FFFF, "R6 thr readback");
    for (int i = 0; i < 6; i++) drive_ts(ts_in + 1, "R1 R2 toggle eval full thr");
    drive_ts(ts_in, "R5 valid drops without toggle");
    drive_ts(ts_in + 32'h100, "R1 upper bits only no eval");
    drive_ts(ts_in + 32'h1, "R1 eval after idle R2 no skipped step");
  endtask

  task automatic t_mid_thr();
    int hits = 0;
    wr_reg(0, 32'h8000_0000);
    for (int i = 0; i < 60; i++) begin
      drive_ts(ts_in + 1, "R3 mid threshold compare");
      if (m_rng < m_thr) hits++;
      if (i % 7 == 3) drive_ts(ts_in + 32'h2, "R1 even step no eval");
    end
    checks++;
    if (hits == 0 || hits == 60) begin
      errors++;
      $display("FAIL R3 mid thr mix: actual=%0d expected between 1 and 59", hits);
    end
  endtask

  task automatic t_same_cycle_write();
    // thr 0 -> FFFFFFFF written in the cycle of a toggle: old thr applies
    wr_reg(0, 32'h0);
    reg_wr = 1; reg_addr = 0; reg_wdata = 32'hFFFF_FFFF;
    ts_in = ts_in + 1;
    @(posedge clk); #1;
    m_rng = model_step(m_rng);
    chk("R6 write same cycle uses old thr", 72'(trg_valid), 72'd0);
    @(negedge clk);
    reg_wr = 0; m_thr = 32'hFFFF_FFFF;
    drive_ts(ts_in + 1, "R6 new thr on next eval");
    chk("R6 new thr fires", 72'(trg_valid), 72'(m_rng < m_thr));
    // FFFFFFFF -> 0 in the cycle of a toggle
    reg_wr = 1; reg_addr = 0; reg_wdata = 32'h0;
    ts_in = ts_in + 1;
    @(posedge clk); #1;
    m_rng = model_step(m_rng);
    chk("R6 old full thr still fires", 72'(trg_valid), 72'(m_rng < 32'hFFFF_FFFF));
    @(negedge clk);
    reg_wr = 0; m_thr = 0;
    drive_ts(ts_in + 1, "R6 zero thr after write");
  endtask

  task automatic t_errors();
    rd_check(1, 32'h0, "R7 err clear before");
    wr_reg(1, 32'h1234);
    rd_check(1, 32'h2, "R7 ro write flags bit1");
    rd_check(4'h5, 32'h0, "R8 bad read returns zero");
    rd_check(1, 32'h3, "R8 bad read flags bit0 R9 sticky");
    wr_reg(4'hF, 32'h55);
    rd_check(0, 32'h0, "R8 bad write leaves thr");
    rd_check(1, 32'h3, "R9 err sticky");
  endtask

  task automatic t_reset_clears();
    wr_reg(0, 32'hFFFF_FFFF);
    do_reset();
    rd_check(0, 32'h0, "R9 reset clears thr");
    rd_check(1, 32'h0, "R9 reset clears err");
    wr_reg(0, 32'hFFFF_FFFF);
    drive_ts(ts_in + 1, "R2 reseeded after reset");
  endtask

  task automatic t_prime();
    // LSB differs from reset reference at release: no eval in first cycle
    @(negedge clk);
    rst = 1; ts_in = 32'h0000_0011;
    repeat (2) @(negedge clk);
    rst = 0;
    m_rng = 32'h2545F491;
    @(posedge clk); #1;
    chk("R10 no eval on first cycle", 72'(trg_valid), 72'd0);
    @(negedge clk);
    wr_reg(0, 32'hFFFF_FFFF);
    drive_ts(32'h0000_0012, "R10 first real toggle uses first number");
  endtask

  initial begin
    rst = 1; ts_in = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    do_reset();
    t_reset_state();
    t_zero_thr();
    t_full_thr();
    t_mid_thr();
    t_same_cycle_write();
    t_errors();
    t_reset_clears();
    t_prime();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule